// File: doc/BRIEF.md
# SD Data-Line Block Engine

This engine moves fixed-length data blocks over the data lines of an SD bus. It works with either one line or four. On transmit it pulls bytes one at a time from a block buffer and sends them out. Each active line gets its own start bit, its own CRC16 and its own end bit. After the block it listens on line 0 for the card's CRC status token and then follows the programming busy period.

On receive it waits for a start bit on line 0 and rebuilds the bytes. It checks the CRC of every active line on its own, checks every end bit, and reports the result once the frame ends.

The engine starts in one-line mode. Four-line mode comes only from an explicit width write while the engine is idle. Command-line traffic, bus clock generation and the card state machine are handled elsewhere.

Top module: `sd_dat_engine`

## Requirements
- R1: After reset the engine is idle in one-line mode. `dat_oe`, `wr_busy`, `st_valid`, `rx_valid`, `rx_done` and `tx_take` are all 0.
- R2: A pulse on `width_wr` while idle selects four-line mode when `width_wide` is 1 and one-line mode when it is 0. In one-line mode only DAT0 is driven (`dat_oe` = 0001).
- R3: A transmitted frame has the same layout on every active line: one start bit of 0, then the data, then 16 CRC bits, then one end bit of 1. `dat_oe` covers exactly that span. In one-line mode each byte leaves MSB first on DAT0. In four-line mode byte bits [7:4] go out on the first clock and bits [3:0] on the second, with nibble bit n on DATn.
- R4: Each active line carries its own CRC16 over its own data bits. The polynomial is x^16+x^12+x^5+1, the register starts at zero, and the CRC is sent MSB first.
- R5: `tx_byte` is taken at every rising edge where `tx_take` is 1. The first byte is taken in the start-bit cycle and the next byte in the last bit cycle of the current byte. Exactly BLK_BYTES bytes are taken per block.
- R6: After a transmitted block the engine reads a status token on DAT0 only. The token is a start bit of 0, three status bits (MSB first) and an end bit. With the token's end bit sampled, `st_valid` pulses. Code 010 sets `st_accept` and code 101 sets `st_crc_bad`. DAT3..DAT1 have no effect.
- R7: `wr_busy` is 1 from the clock after the token end bit until DAT0 is sampled high. DAT3..DAT1 do not end busy.
- R8: A received block is delivered as BLK_BYTES pulses of `rx_valid` with `rx_byte`, using the bit order of R3.
- R9: `rx_crc_err` is set with `rx_done` when the CRC of any active line mismatches. Inactive lines never raise it.
- R10: `rx_frame_err` is set with `rx_done` when the end bit of any active line is 0. Inactive lines never raise it.
- R11: A width write while a transfer is in progress has no effect on the current or later transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock, one data bit per line per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| width_wr | input | 1 | Width write strobe |
| width_wide | input | 1 | Width value: 1 selects four lines |
| tx_start | input | 1 | Begin sending one block |
| tx_byte | input | 8 | Next byte from the block buffer |
| tx_take | output | 1 | `tx_byte` is consumed at this edge |
| rx_start | input | 1 | Arm the receiver for one block |
| rx_byte | output | 8 | Received byte |
| rx_valid | output | 1 | `rx_byte` is valid this cycle |
| rx_done | output | 1 | Receive finished; error flags updated |
| rx_crc_err | output | 1 | CRC mismatch on some active line |
| rx_frame_err | output | 1 | End bit missing on some active line |
| st_valid | output | 1 | Status token decoded this cycle |
| st_accept | output | 1 | Token code was 010 |
| st_crc_bad | output | 1 | Token code was 101 |
| wr_busy | output | 1 | Card is signalling programming busy |
| dat_i | input | 4 | Sampled DAT3..DAT0 |
| dat_o | output | 4 | DAT3..DAT0 drive values |
| dat_oe | output | 4 | DAT3..DAT0 output enables |

## Verification
The bench builds the engine with BLK_BYTES = 4. That keeps a whole frame short, so every transmitted cycle can be compared against a behavioural model in both widths. Many complete write and read sequences fit in a short run. Among them are a corrupted CRC on one line, a missing end bit on line 3, a width write in the middle of a block, and noise on the unused lines and during the status token and busy.

// File: rtl/sd_dat_engine.sv
module sd_dat_engine #(
  parameter int BLK_BYTES = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       width_wr,
  input  logic       width_wide,
  input  logic       tx_start,
  input  logic [7:0] tx_byte,
  output logic       tx_take,
  input  logic       rx_start,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  output logic       rx_done,
  output logic       rx_crc_err,
  output logic       rx_frame_err,
  output logic       st_valid,
  output logic       st_accept,
  output logic       st_crc_bad,
  output logic       wr_busy,
  input  logic [3:0] dat_i,
  output logic [3:0] dat_o,
  output logic [3:0] dat_oe
);
  localparam int BW = $clog2(BLK_BYTES + 1);
  localparam logic [BW-1:0] LAST_BYTE = BW'(BLK_BYTES - 1);

  typedef enum logic [3:0] {
    IDLE, T_START, T_DATA, T_CRC, T_END, S_WAIT, S_BITS, S_BUSY,
    R_WAIT, R_DATA, R_CRC, R_END
  } state_t;

  state_t state;
  logic wide_q;
  logic [7:0] sh;
  logic [2:0] bit_q;
  logic [BW-1:0] byte_q;
  logic [3:0] cnt;
  logic [2:0] tok;
  logic [3:0][15:0] crc;
  logic crc_bad;

  function automatic logic [15:0] crc_step(logic [15:0] c, logic b);
    return {c[14:0], 1'b0} ^ ((b ^ c[15]) ? 16'h1021 : 16'h0000);
  endfunction

  wire [3:0] act = wide_q ? 4'hF : 4'h1;
  wire last_bit = wide_q ? (bit_q == 3'd1) : (bit_q == 3'd7);
  wire last_byte = byte_q == LAST_BYTE;
  wire [7:0] rx_next = wide_q ? {sh[3:0], dat_i} : {sh[6:0], dat_i[0]};
  wire in_tx = state inside {T_START, T_DATA, T_CRC, T_END};

  assign dat_oe = in_tx ? act : 4'h0;
  assign tx_take = (state == T_START) || (state == T_DATA && last_bit && !last_byte);
  assign wr_busy = state == S_BUSY;

  always_comb begin
    dat_o = 4'hF;
    case (state)
      T_START: dat_o = ~act;
      T_DATA:  dat_o = wide_q ? sh[7:4] : {3'b111, sh[7]};
      T_CRC:   for (int l = 0; l < 4; l++) dat_o[l] = crc[l][15] | ~act[l];
      default: dat_o = 4'hF;
    endcase
  end

  always_comb begin
    crc_bad = 1'b0;
    for (int l = 0; l < 4; l++)
      if (act[l] && crc[l] != 16'h0) crc_bad = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) crc <= '0;
    else
      for (int l = 0; l < 4; l++)
        if (state == T_START || state == R_WAIT) crc[l] <= 16'h0;
        else if (state == T_DATA) crc[l] <= crc_step(crc[l], dat_o[l]);
        else if (state == R_DATA || state == R_CRC) crc[l] <= crc_step(crc[l], dat_i[l]);
        else if (state == T_CRC) crc[l] <= {crc[l][14:0], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE; wide_q <= 1'b0; sh <= '0; bit_q <= '0; byte_q <= '0;
      cnt <= '0; tok <= '0; rx_byte <= '0; rx_valid <= 1'b0; rx_done <= 1'b0;
      rx_crc_err <= 1'b0; rx_frame_err <= 1'b0;
      st_valid <= 1'b0; st_accept <= 1'b0; st_crc_bad <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rx_done <= 1'b0;
      st_valid <= 1'b0;
      case (state)
        IDLE: begin
          if (width_wr) wide_q <= width_wide;
          if (tx_start) state <= T_START;
          else if (rx_start) state <= R_WAIT;
        end
        T_START: begin
          sh <= tx_byte; bit_q <= '0; byte_q <= '0; state <= T_DATA;
        end
        T_DATA: begin
          if (last_bit) begin
            bit_q <= '0;
            if (last_byte) begin state <= T_CRC; cnt <= '0; end
            else begin byte_q <= byte_q + 1'b1; sh <= tx_byte; end
          end else begin
            bit_q <= bit_q + 1'b1;
            sh <= wide_q ? {sh[3:0], 4'h0} : {sh[6:0], 1'b0};
          end
        end
        T_CRC: begin
          cnt <= cnt + 1'b1;
          if (cnt == 4'd15) state <= T_END;
        end
        T_END: state <= S_WAIT;
        S_WAIT: if (!dat_i[0]) begin state <= S_BITS; cnt <= '0; end
        S_BITS: begin
          if (cnt == 4'd3) begin
            st_valid <= 1'b1;
            st_accept <= tok == 3'b010;
            st_crc_bad <= tok == 3'b101;
            state <= S_BUSY;
          end else begin
            tok <= {tok[1:0], dat_i[0]};
            cnt <= cnt + 1'b1;
          end
        end
        S_BUSY: if (dat_i[0]) state <= IDLE;
        R_WAIT: if (!dat_i[0]) begin
          state <= R_DATA; bit_q <= '0; byte_q <= '0;
        end
        R_DATA: begin
          sh <= rx_next;
          if (last_bit) begin
            rx_byte <= rx_next; rx_valid <= 1'b1; bit_q <= '0;
            if (last_byte) begin state <= R_CRC; cnt <= '0; end
            else byte_q <= byte_q + 1'b1;
          end else bit_q <= bit_q + 1'b1;
        end
        R_CRC: begin
          cnt <= cnt + 1'b1;
          if (cnt == 4'd15) state <= R_END;
        end
        R_END: begin
          rx_done <= 1'b1;
          rx_crc_err <= crc_bad;
          rx_frame_err <= |(act & ~dat_i);
          state <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end

  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|dat_oe) |-> (dat_o & dat_oe) == 4'h0);
  p_end_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|dat_oe) |-> $past(dat_o & dat_oe) == $past(dat_oe));
  p_narrow_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_q && |dat_oe) |-> dat_oe == 4'b0001);
  p_width_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state != IDLE) |=> $stable(wide_q));
  p_token_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> !(st_accept && st_crc_bad));
  p_busy_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> dat_oe == 4'h0);
  p_take_driving_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> |dat_oe);
endmodule

// File: tb/test_sd_dat_engine.sv
module test_sd_dat_engine;
  localparam int BLK = 4;
  logic clk = 0, rst_n = 0;
  logic width_wr = 0, width_wide = 0, tx_start = 0, rx_start = 0;
  logic [7:0] tx_byte;
  logic tx_take, rx_valid, rx_done, rx_crc_err, rx_frame_err;
  logic st_valid, st_accept, st_crc_bad, wr_busy;
  logic [7:0] rx_byte;
  logic [3:0] dat_i = 4'hF, dat_o, dat_oe;

  int checks = 0, failures = 0, tidx = 0, g = 0;
  logic [7:0] mem [BLK];
  logic [3:0] frame [$];
  logic [7:0] exp_q [$];
  logic [7:0] got_q [$];
  bit mon_on = 0;

  always #4 clk = ~clk;

  sd_dat_engine #(.BLK_BYTES(BLK)) i_sd_dat_engine (
    .clk(clk), .rst_n(rst_n), .width_wr(width_wr), .width_wide(width_wide),
    .tx_start(tx_start), .tx_byte(tx_byte), .tx_take(tx_take),
    .rx_start(rx_start), .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_done(rx_done),
    .rx_crc_err(rx_crc_err), .rx_frame_err(rx_frame_err),
    .st_valid(st_valid), .st_accept(st_accept), .st_crc_bad(st_crc_bad),
    .wr_busy(wr_busy), .dat_i(dat_i), .dat_o(dat_o), .dat_oe(dat_oe));

  assign tx_byte = (tidx < BLK) ? mem[tidx] : 8'hEE;
  always @(posedge clk) if (tx_start) tidx <= 0; else if (tx_take) tidx <= tidx + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Cycle reference for the data-line drive (R3 R4), compared on every clock
  always @(negedge clk) if (mon_on) begin
    logic [7:0] e;
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
    chk({dat_oe, dat_o & dat_oe} == e, "R3 R4 drive {oe,dat}", {dat_oe, dat_o & dat_oe}, e);
    if (rx_valid) got_q.push_back(rx_byte);
  end

  task automatic fill(input int seed);
    for (int i = 0; i < BLK; i++) mem[i] = 8'(seed * 37 + i * 91 + 8'h5A);
  endtask

  task automatic build(input bit wide, input int bad_crc, input int bad_end);
    logic [15:0] c [4];
    logic [3:0] v;
    logic fb;
    frame.delete();
    for (int l = 0; l < 4; l++) c[l] = 16'h0;
    frame.push_back(4'h0);
    for (int i = 0; i < BLK; i++)
      for (int k = (wide ? 1 : 7); k >= 0; k--) begin
        v = wide ? (k == 1 ? mem[i][7:4] : mem[i][3:0]) : {3'b000, mem[i][k]};
        frame.push_back(v);
        for (int l = 0; l < 4; l++) begin
          fb = v[l] ^ c[l][15];
          c[l] = {c[l][14:0], 1'b0};
          if (fb) c[l] = c[l] ^ 16'h1021;
        end
      end
    for (int k = 15; k >= 0; k--) begin
      for (int l = 0; l < 4; l++) v[l] = c[l][k];
      if (bad_crc >= 0 && k == 0) v[bad_crc] = ~v[bad_crc];
      frame.push_back(v);
    end
    v = 4'hF;
    if (bad_end >= 0) v[bad_end] = 1'b0;
    frame.push_back(v);
  endtask

  task automatic step;
    @(negedge clk); #1;
  endtask

  task automatic set_width(input bit w);
    step; width_wr = 1; width_wide = w;
    step; width_wr = 0;
  endtask

  task automatic do_tx(input bit wide, input int seed, input bit mid_write);
    logic [3:0] a;
    a = wide ? 4'hF : 4'h1;
    fill(seed);
    build(wide, -1, -1);
    step;
    tx_start = 1;
    foreach (frame[i]) exp_q.push_back({a, frame[i] & a});
    step; tx_start = 0;
    if (mid_write) begin
      step; width_wr = 1; width_wide = ~wide;
      step; width_wr = 0;
    end
    wait (exp_q.size() == 0);
    chk(tidx == BLK, "R5 bytes taken", tidx, BLK);
  endtask

  task automatic do_status(input logic [2:0] code, input bit noise);
    logic [4:0] tk;
    tk = {1'b0, code, 1'b1};
    step;
    for (int i = 4; i >= 0; i--) begin
      dat_i = {(noise ? ~{3{tk[i]}} : 3'b111), tk[i]};
      step;
    end
    chk(st_valid == 1, "R6 st_valid", st_valid, 1);
    chk(st_accept == (code == 3'b010), "R6 st_accept", st_accept, code == 3'b010);
    chk(st_crc_bad == (code == 3'b101), "R6 st_crc_bad", st_crc_bad, code == 3'b101);
    for (int i = 0; i < 3; i++) begin
      chk(wr_busy == 1, "R7 busy held", wr_busy, 1);
      dat_i = {(noise ? 3'b111 : 3'b000), 1'b0};
      step;
    end
    chk(wr_busy == 1, "R7 busy held", wr_busy, 1);
    dat_i = 4'hF;
    step;
    chk(wr_busy == 0, "R7 busy released", wr_busy, 0);
  endtask

  task automatic do_rx(input bit wide, input int seed, input int bad_crc, input int bad_end);
    logic [3:0] a;
    a = wide ? 4'hF : 4'h1;
    fill(seed);
    build(wide, bad_crc, bad_end);
    got_q.delete();
    step; rx_start = 1;
    step; rx_start = 0;
    foreach (frame[i]) begin
      g++;
      dat_i = (frame[i] & a) | (4'(g * 5) & ~a);
      step;
    end
    dat_i = 4'hF;
    chk(rx_done == 1, "R8 rx_done", rx_done, 1);
    chk(rx_crc_err == (bad_crc >= 0 && a[bad_crc]), "R9 crc flag", rx_crc_err, bad_crc >= 0 && a[bad_crc]);
    chk(rx_frame_err == (bad_end >= 0 && a[bad_end]), "R10 end flag", rx_frame_err, bad_end >= 0 && a[bad_end]);
    step;
    chk(got_q.size() == BLK, "R8 byte count", got_q.size(), BLK);
    for (int i = 0; i < BLK && i < got_q.size(); i++)
      chk(got_q[i] == mem[i], "R8 rx byte", got_q[i], mem[i]);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(dat_oe == 0, "R1 oe", dat_oe, 0);
    chk({wr_busy, st_valid, rx_valid, rx_done, tx_take} == 0, "R1 flags",
        {wr_busy, st_valid, rx_valid, rx_done, tx_take}, 0);
    mon_on = 1;
    do_tx(0, 1, 0);              // R2 default narrow, R3 R4 R5
    do_status(3'b010, 0);        // R6 accepted, R7
    set_width(1);                // R2
    do_tx(1, 2, 1);              // R3 R4 wide, R11 width write ignored mid-block
    do_status(3'b101, 1);        // R6 crc-bad, noise on DAT3..1, R7
    do_tx(1, 3, 0);              // R11 still wide afterwards
    do_status(3'b010, 1);
    do_rx(1, 4, -1, -1);         // R8 wide good
    do_rx(1, 5, 2, -1);          // R9 line 2 crc
    do_rx(1, 6, -1, 3);          // R10 line 3 end bit
    set_width(0);                // R2 back to narrow
    do_rx(0, 7, -1, -1);         // R8 narrow
    do_rx(0, 8, 1, 2);           // R9 R10 inactive lines ignored
    do_rx(0, 9, 0, -1);          // R9 narrow crc error
    do_tx(0, 10, 0);
    do_status(3'b010, 1);
    mon_on = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule